// File: doc/BRIEF.md
# GPIO Peripheral Trigger Generator

This block turns per-pin GPIO events into start signals for an analog converter and a DMA engine. Each pin level is first synchronized to the block clock. Each pin is then classed as edge or level sensitive, with a chosen polarity, and its event is detected. Events from the pins enabled for the converter merge into a start pulse one cycle wide. Events from the pins enabled for DMA, when their interrupt mask bit allows them, raise a request line. That line stays up until the DMA engine returns a done strobe.

A sticky raw status vector records every pin event. One extra bit above the pin bits records DMA completion. Software clears status bits by writing ones to a clear vector. When no pin is enabled for the converter, one fixed fallback pin still starts it, so older setups keep working.

Top module: `gpio_trig_gen`

## Requirements
- R1: A pin event drives `adc_trig_o` only when that pin's bit in `adc_en_i` is 1, as long as `adc_en_i` is not all zero.
- R2: `adc_trig_o` is never high for two cycles in a row. An event that arrives in the cycle right after a pulse is merged into that pulse.
- R3: A level-sensitive pin (`level_i` bit = 1) gives exactly one start pulse per assertion. It gives another only after the level goes inactive and returns.
- R4: When `adc_en_i` is all zero, the pin at index `LEGACY_PIN` (default 4) still triggers `adc_trig_o`, and no other pin does.
- R5: Several enabled pins firing in the same cycle give a single pulse one cycle wide.
- R6: `dma_req_o` rises only after an event on a pin whose bits are set in both `dma_en_i` and `im_i`.
- R7: A `dma_done_i` strobe sets `ris_o[NUM_PINS]` on the next clock edge.
- R8: `ris_o` bits are sticky. Writing 1 to the matching `icr_i` bit clears a bit. A new event in the same cycle wins over the clear.
- R9: `dma_req_o` holds until `dma_done_i`. It is then low for the two cycles after the strobe.
- R10: Event encoding: `level_i` bit 0 means edge, 1 means level. `pol_hi_i` bit 1 means rising or high, 0 means falling or low. A pin change shows on the outputs at the third rising clock edge after it.
- R11: After reset `adc_trig_o`, `dma_req_o` and `ris_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw pin levels |
| level_i | input | NUM_PINS | Per-pin event kind, 1 = level |
| pol_hi_i | input | NUM_PINS | Per-pin polarity, 1 = rising/high |
| im_i | input | NUM_PINS | Interrupt mask, 1 = not masked |
| adc_en_i | input | NUM_PINS | Converter trigger enable per pin |
| dma_en_i | input | NUM_PINS | DMA trigger enable per pin |
| icr_i | input | NUM_PINS+1 | Write-one-to-clear strobes for status |
| dma_done_i | input | 1 | DMA completion strobe |
| adc_trig_o | output | 1 | Converter start pulse |
| dma_req_o | output | 1 | DMA request |
| ris_o | output | NUM_PINS+1 | Raw status; top bit is DMA done |

## Verification
The assertions assume that `dma_done_i` is a strobe one cycle wide. They also assume it only comes while a request is pending, and that configuration inputs change only while no event is in flight. The bench changes configuration only between scenarios, after the pins have settled. It pulses the done strobe once per request, and it drives every input on the falling edge so each settles well before the rising edge.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
  typedef enum logic {
    EV_EDGE  = 1'b0,
    EV_LEVEL = 1'b1
  } ev_kind_e;

  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_BUSY = 2'd1,
    REQ_HOLD = 2'd2
  } req_state_e;
endpackage

// File: rtl/gpio_trig_sync.sv
module gpio_trig_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= '0;
      else         stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic level_i,
  input  logic pol_hi_i,
  output logic event_o,
  output logic fire_o
);
  logic prev_q, armed_q;
  logic active, edge_hit;
  ev_kind_e kind;

  assign kind     = ev_kind_e'(level_i);
  assign active   = pol_hi_i ? pin_s_i : ~pin_s_i;
  assign edge_hit = pol_hi_i ? (pin_s_i & ~prev_q) : (~pin_s_i & prev_q);

  always_comb begin
    if (kind == EV_LEVEL) begin
      event_o = active;
      fire_o  = active & armed_q;
    end else begin
      event_o = edge_hit;
      fire_o  = edge_hit;
    end
  end

  // re-arm a level pin once it goes inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      prev_q <= pin_s_i;
      if (!active)     armed_q <= 1'b1;
      else if (fire_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_trig_dma.sv
module gpio_trig_dma
  import gpio_trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic done_i,
  output logic req_o
);
  req_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      REQ_IDLE: if (done_i) state_d = REQ_HOLD;
                else if (hit_i) state_d = REQ_BUSY;
      REQ_BUSY: if (done_i) state_d = REQ_HOLD;
      REQ_HOLD: state_d = done_i ? REQ_HOLD : REQ_IDLE;
      default:  state_d = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REQ_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = (state_q == REQ_BUSY);
endmodule

// File: rtl/gpio_trig_gen.sv
module gpio_trig_gen #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned LEGACY_PIN  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] pol_hi_i,
  input  logic [NUM_PINS-1:0] im_i,
  input  logic [NUM_PINS-1:0] adc_en_i,
  input  logic [NUM_PINS-1:0] dma_en_i,
  input  logic [NUM_PINS:0]   icr_i,
  input  logic                dma_done_i,
  output logic                adc_trig_o,
  output logic                dma_req_o,
  output logic [NUM_PINS:0]   ris_o
);
  localparam int unsigned RisW = NUM_PINS + 1;
  localparam logic [NUM_PINS-1:0] LegacyMask =
    {{(NUM_PINS-1){1'b0}}, 1'b1} << LEGACY_PIN;

  logic [NUM_PINS-1:0] pin_s, ev, fire, adc_sel;
  logic [RisW-1:0]     set_vec;
  logic [RisW-1:0]     ris_q;
  logic                adc_q, adc_any, dma_hit;

  gpio_trig_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_trig_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_s_i (pin_s[i]),
      .level_i (level_i[i]),
      .pol_hi_i(pol_hi_i[i]),
      .event_o (ev[i]),
      .fire_o  (fire[i])
    );
  end

  // fallback source when no pin is selected
  assign adc_sel = (adc_en_i == '0) ? LegacyMask : adc_en_i;
  assign adc_any = |(fire & adc_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) adc_q <= 1'b0;
    else         adc_q <= adc_any & ~adc_q;
  end
  assign adc_trig_o = adc_q;

  assign dma_hit = |(ev & dma_en_i & im_i);

  gpio_trig_dma u_dma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (dma_hit),
    .done_i(dma_done_i),
    .req_o (dma_req_o)
  );

  assign set_vec = {dma_done_i, ev};

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ris_q <= '0;
    else         ris_q <= set_vec | (ris_q & ~icr_i);
  end
  assign ris_o = ris_q;
endmodule

// File: rtl/gpio_trig_chk.sv
module gpio_trig_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] im_i,
  input logic [NUM_PINS-1:0] dma_en_i,
  input logic [NUM_PINS:0]   icr_i,
  input logic                dma_done_i,
  input logic                adc_trig_o,
  input logic                dma_req_o,
  input logic [NUM_PINS:0]   ris_o
);
  p_adc_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_trig_o |=> !adc_trig_o);

  p_req_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> $past((im_i & dma_en_i) != '0));

  p_done_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> ris_o[NUM_PINS]);

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ris_o[NUM_PINS]) |-> $past(icr_i[NUM_PINS]));

  p_req_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> !dma_req_o ##1 !dma_req_o);
endmodule

bind gpio_trig_gen gpio_trig_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .im_i      (im_i),
  .dma_en_i  (dma_en_i),
  .icr_i     (icr_i),
  .dma_done_i(dma_done_i),
  .adc_trig_o(adc_trig_o),
  .dma_req_o (dma_req_o),
  .ris_o     (ris_o)
);

// File: tb/gpio_trig_gen_tb.sv
module gpio_trig_gen_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, level = 8'h08, pol_hi = 8'hFB;
  logic [N-1:0] im = '0, adc_en = '0, dma_en = '0;
  logic [N:0]   icr = '0;
  logic         dma_done = 1'b0;
  logic         adc_trig, dma_req;
  logic [N:0]   ris;
  int           n_chk = 0, n_err = 0;
  bit           done_flag = 0;

  always #4 clk = ~clk;

  gpio_trig_gen #(.NUM_PINS(N), .LEGACY_PIN(4), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .level_i(level),
    .pol_hi_i(pol_hi), .im_i(im), .adc_en_i(adc_en), .dma_en_i(dma_en),
    .icr_i(icr), .dma_done_i(dma_done), .adc_trig_o(adc_trig),
    .dma_req_o(dma_req), .ris_o(ris)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_pin(input logic [N-1:0] v);
    @(negedge clk);
    pin = v;
  endtask

  task automatic clear_all();
    @(negedge clk);
    icr = '1;
    @(negedge clk);
    icr = '0;
  endtask

  task automatic t_reset();
    chk("R11 adc", adc_trig, 0);
    chk("R11 req", dma_req, 0);
    chk("R11 ris", ris, 0);
  endtask

  task automatic t_enable();
    adc_en = 8'h01;
    clear_all();
    drive_pin(8'h01);
    edges(3);
    chk("R10 R1 rise pin0 trig", adc_trig, 1);
    chk("R10 ris pin0", ris[0], 1);
    edges(1);
    chk("R2 pulse width", adc_trig, 0);
    drive_pin(8'h03);
    edges(3);
    chk("R1 disabled pin1 no trig", adc_trig, 0);
    chk("R1 pin1 status", ris[1], 1);
    drive_pin(8'h00);
    edges(4);
  endtask

  task automatic t_falling();
    adc_en = 8'h04;
    drive_pin(8'h04);
    edges(3);
    chk("R10 rise on falling pin", adc_trig, 0);
    drive_pin(8'h00);
    edges(3);
    chk("R10 fall pin2 trig", adc_trig, 1);
    edges(2);
  endtask

  task automatic t_level();
    int extra = 0;
    adc_en = 8'h08;
    drive_pin(8'h08);
    edges(3);
    chk("R3 level first pulse", adc_trig, 1);
    for (int k = 0; k < 10; k++) begin
      edges(1);
      if (adc_trig) extra++;
    end
    chk("R3 no repeat while held", extra, 0);
    @(negedge clk);
    icr = 9'h008;
    @(negedge clk);
    icr = '0;
    chk("R8 set wins over clear", ris[3], 1);
    drive_pin(8'h00);
    edges(5);
    drive_pin(8'h08);
    edges(3);
    chk("R3 re-armed pulse", adc_trig, 1);
    drive_pin(8'h00);
    edges(4);
  endtask

  task automatic t_legacy();
    adc_en = 8'h00;
    drive_pin(8'h10);
    edges(3);
    chk("R4 legacy pin trig", adc_trig, 1);
    drive_pin(8'h30);
    edges(3);
    chk("R4 other pin ignored", adc_trig, 0);
    drive_pin(8'h00);
    edges(3);
    adc_en = 8'h20;
    drive_pin(8'h10);
    edges(3);
    chk("R4 legacy off when enabled", adc_trig, 0);
    drive_pin(8'h00);
    edges(4);
  endtask

  task automatic t_combined();
    adc_en = 8'h03;
    drive_pin(8'h03);
    edges(3);
    chk("R5 combined pulse", adc_trig, 1);
    edges(1);
    chk("R5 single cycle", adc_trig, 0);
    drive_pin(8'h00);
    edges(4);
    drive_pin(8'h01);
    drive_pin(8'h03);
    edges(2);
    chk("R2 first of back-to-back", adc_trig, 1);
    edges(1);
    chk("R2 second merged", adc_trig, 0);
    drive_pin(8'h00);
    edges(4);
  endtask

  task automatic t_dma();
    adc_en = 8'h00;
    dma_en = 8'h01;
    im = 8'h00;
    clear_all();
    drive_pin(8'h01);
    edges(3);
    chk("R6 masked no req", dma_req, 0);
    drive_pin(8'h00);
    edges(4);
    im = 8'h01;
    drive_pin(8'h01);
    edges(3);
    chk("R6 unmasked req", dma_req, 1);
    edges(5);
    chk("R9 req held", dma_req, 1);
    @(negedge clk);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk("R9 req dropped", dma_req, 0);
    chk("R7 done status", ris[N], 1);
    edges(1);
    chk("R9 still low", dma_req, 0);
    edges(6);
    chk("R8 done sticky", ris[N], 1);
    drive_pin(8'h00);
    edges(4);
  endtask

  task automatic t_clear();
    @(negedge clk);
    icr = 9'h100;
    @(negedge clk);
    icr = '0;
    chk("R8 done cleared", ris[N], 0);
    chk("R8 pin0 kept", ris[0], 1);
    clear_all();
    chk("R8 all cleared", ris, 0);
  endtask

  initial begin
    #1;
    t_reset();
    edges(2);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);
    t_reset();
    t_enable();
    t_falling();
    t_level();
    t_legacy();
    t_combined();
    t_dma();
    t_clear();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule